// File: doc/BRIEF.md
# Periodic Down-Counting Timer

This block is one timer channel with a prescaler. A 32-bit counter counts down by one for every prescaled tick. The prescaled tick is made from an external tick-enable pulse. Some other block decides how fast that pulse comes, for example from a slow reference clock or a faster timer clock. Software programs the channel through a small register port with four words: a reload value, the live count, a control word and an interrupt status word.

While the channel is running, the prescaler passes on every tick-enable pulse, every sixteenth pulse or every 256th pulse. What happens when the count reaches zero depends on the mode:

- In periodic mode, the next prescaled tick reloads the counter from the reload register and raises a pending interrupt.
- In the other mode, the counter stays at zero but still flags the event.

The interrupt output is the pending flag gated by an enable bit. Any write to the status word clears the pending flag.

Top module: `periodic_timer`

## Requirements
- R1: After reset, every register reads back zero and `irq` is low.
- R2: Register addresses on `bus_addr`:
  - 0 is the reload value (read/write).
  - 1 is the live count (read/write).
  - 2 is the control word (read/write). Only bits 4:0 are stored and the upper bits read as zero.
  - 3 is status. It reads bit 0 = pending and bit 1 = `irq`, all other bits zero. A write to it clears pending, whatever the data.
- R3: While control bit 0 (run) is set, each prescaled tick lowers a nonzero count by exactly one.
- R4: Control bits 4:3 pick the prescale:
  - 00 and 11 pass every `tick_en` pulse.
  - 01 passes every 16th pulse.
  - 10 passes every 256th pulse.
  - The prescale count restarts on any control write and stays cleared while run is 0.
- R5: With control bit 1 (periodic) set, a prescaled tick that finds the count at zero loads the count from the reload register.
- R6: A prescaled tick that finds the count at zero sets the pending flag. `irq` equals pending AND control bit 2 (interrupt enable).
- R7: A write to address 3 clears pending on the next edge. If a new zero-count event occurs in the same cycle, pending stays set.
- R8: With periodic clear, a prescaled tick at zero leaves the count at zero, and each such tick sets pending again.
- R9: Writing 0 to the control word stops the counter. `tick_en` pulses are then ignored and the count holds its value.
- R10: A write to address 1 sets the count on the next edge. It takes priority over a decrement or reload in the same cycle.
- R11: A write to the reload register does not change the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-rate enable pulse from the clock-source select |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Masked interrupt |

## Verification
Two functions can fall in the same cycle:

- A software clear of the pending flag and a zero-count event that sets it again.
- A direct write of the count and a decrement or reload.

The bench provokes the first by writing the status word on every cycle while ticking at the undivided rate through several reload periods. Random traffic adds collisions of both kinds. A cycle model built from the requirements predicts the outcome: set beats clear, and write beats decrement. Every cycle's read data and `irq` are compared against that model.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int CTRL_W = 5;

    typedef enum logic [1:0] {
        A_LOAD  = 2'd0,
        A_VALUE = 2'd1,
        A_CTRL  = 2'd2,
        A_STAT  = 2'd3
    } ptmr_addr_e;

    typedef enum logic [1:0] {
        SC_DIV1     = 2'd0,
        SC_DIV_MID  = 2'd1,
        SC_DIV_HIGH = 2'd2,
        SC_DIV1_ALT = 2'd3
    } ptmr_scale_e;

    // bit 0 run, bit 1 periodic, bit 2 irq enable, bits 4:3 prescale
    typedef struct packed {
        logic [1:0] scale;
        logic       irq_en;
        logic       periodic;
        logic       run;
    } ptmr_ctrl_t;

endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] value_i,
    input  logic          pend_i,
    input  logic          irq_i,
    output logic [DW-1:0] load_o,
    output ptmr_ctrl_t    ctrl_o,
    output logic          ctrl_wr_o,
    output logic          val_wr_o,
    output logic          clr_o,
    output logic [DW-1:0] rdata_o
);

    typedef struct packed {
        logic [DW-1:0] load;
        ptmr_ctrl_t    ctrl;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        ctrl_wr_o = wr_en && (addr == A_CTRL);
        val_wr_o  = wr_en && (addr == A_VALUE);
        clr_o     = wr_en && (addr == A_STAT);
        if (wr_en && (addr == A_LOAD)) d.load = wdata;
        if (ctrl_wr_o)                 d.ctrl = ptmr_ctrl_t'(wdata[CTRL_W-1:0]);

        rdata_o = '0;
        case (ptmr_addr_e'(addr))
            A_LOAD:  rdata_o = q.load;
            A_VALUE: rdata_o = value_i;
            A_CTRL:  rdata_o[CTRL_W-1:0] = q.ctrl;
            default: begin
                rdata_o[0] = pend_i;
                rdata_o[1] = irq_i;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign load_o = q.load;
    assign ctrl_o = q.ctrl;

    AST_LOAD_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_LOAD) |=> $stable(load_o)); // R2

endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
    import ptmr_pkg::*;
#(
    parameter int DIV_MID  = 16,
    parameter int DIV_HIGH = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       run_i,
    input  logic [1:0] scale_i,
    input  logic       restart_i,
    output logic       pretick_o
);

    localparam int PW = (DIV_HIGH > 2) ? $clog2(DIV_HIGH) : 1;
    localparam logic [PW-1:0] LIM_MID  = PW'(DIV_MID - 1);
    localparam logic [PW-1:0] LIM_HIGH = PW'(DIV_HIGH - 1);

    typedef struct packed {
        logic [PW-1:0] pcnt;
    } pre_t;

    pre_t q, d;
    logic [PW-1:0] lim;

    always_comb begin
        d = q;
        case (ptmr_scale_e'(scale_i))
            SC_DIV_MID:  lim = LIM_MID;
            SC_DIV_HIGH: lim = LIM_HIGH;
            default:     lim = '0;
        endcase
        pretick_o = tick_en && run_i && (q.pcnt == lim);
        if (restart_i || !run_i) d.pcnt = '0;
        else if (tick_en)        d.pcnt = pretick_o ? '0 : q.pcnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_PRESCALE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i || !run_i) |=> (q.pcnt == '0)); // R4

    AST_PRESCALE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !restart_i && run_i) |=> $stable(q.pcnt)); // R4

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pretick_i,
    input  logic          run_i,
    input  logic          periodic_i,
    input  logic [DW-1:0] load_i,
    input  logic          val_wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          clr_i,
    output logic [DW-1:0] value_o,
    output logic          pend_o
);

    typedef struct packed {
        logic [DW-1:0] value;
        logic          pending;
    } cnt_t;

    cnt_t q, d;
    logic hit;

    always_comb begin
        d   = q;
        hit = pretick_i && (q.value == '0);
        if (val_wr_i)       d.value = wdata_i;
        else if (pretick_i) d.value = hit ? (periodic_i ? load_i : '0) : q.value - 1'b1;
        d.pending = hit || (q.pending && !clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign value_o = q.value;
    assign pend_o  = q.pending;

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pretick_i && value_o != '0 && !val_wr_i) |=> (value_o == $past(value_o) - 1'b1)); // R3

    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pretick_i && value_o == '0 && periodic_i && !val_wr_i) |=> (value_o == $past(load_i))); // R5

    AST_ZERO_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pretick_i && value_o == '0) |=> pend_o); // R6

    AST_CLEAR_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(pretick_i && value_o == '0)) |=> !pend_o); // R7

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pretick_i && value_o == '0 && !periodic_i && !val_wr_i) |=> (value_o == '0)); // R8

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !val_wr_i) |=> $stable(value_o)); // R9

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        val_wr_i |=> (value_o == $past(wdata_i))); // R10

endmodule

// File: rtl/periodic_timer.sv
module periodic_timer
    import ptmr_pkg::*;
#(
    parameter int DW       = 32,
    parameter int DIV_MID  = 16,
    parameter int DIV_HIGH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);

    logic [DW-1:0] load_w, value_w;
    ptmr_ctrl_t    ctrl_w;
    logic          ctrl_wr_w, val_wr_w, clr_w, pend_w, pretick_w;

    ptmr_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .value_i   (value_w),
        .pend_i    (pend_w),
        .irq_i     (irq),
        .load_o    (load_w),
        .ctrl_o    (ctrl_w),
        .ctrl_wr_o (ctrl_wr_w),
        .val_wr_o  (val_wr_w),
        .clr_o     (clr_w),
        .rdata_o   (bus_rdata)
    );

    ptmr_prescaler #(.DIV_MID(DIV_MID), .DIV_HIGH(DIV_HIGH)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .run_i     (ctrl_w.run),
        .scale_i   (ctrl_w.scale),
        .restart_i (ctrl_wr_w),
        .pretick_o (pretick_w)
    );

    ptmr_counter #(.DW(DW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .pretick_i  (pretick_w),
        .run_i      (ctrl_w.run),
        .periodic_i (ctrl_w.periodic),
        .load_i     (load_w),
        .val_wr_i   (val_wr_w),
        .wdata_i    (bus_wdata),
        .clr_i      (clr_w),
        .value_o    (value_w),
        .pend_o     (pend_w)
    );

    assign irq = pend_w && ctrl_w.irq_en;

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend_w); // R6

    AST_RELOAD_WRITE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && !pretick_w) |=> $stable(value_w)); // R11

endmodule

// File: tb/test_periodic_timer.sv
`timescale 1ns/1ps
module test_periodic_timer;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    always #2 clk = ~clk;

    periodic_timer #(.DW(DW)) i_periodic_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    logic [DW-1:0] m_load, m_val;
    logic [4:0]    m_ctrl;
    logic          m_pend;
    int            m_pcnt;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic int lim_of(input logic [1:0] s);
        if (s == 2'd1) return 15;
        if (s == 2'd2) return 255;
        return 0;
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic [1:0] a);
        logic [DW-1:0] r;
        r = '0;
        case (a)
            2'd0: r = m_load;
            2'd1: r = m_val;
            2'd2: r[4:0] = m_ctrl;
            default: begin r[0] = m_pend; r[1] = m_pend & m_ctrl[2]; end
        endcase
        return r;
    endfunction

    task automatic model_step(input logic w, input logic [1:0] a, input logic [DW-1:0] dd, input logic t);
        logic run, pre, hit;
        run = m_ctrl[0];
        pre = t && run && (m_pcnt == lim_of(m_ctrl[4:3]));
        hit = pre && (m_val == '0);
        if ((w && a == 2'd2) || !run) m_pcnt = 0;
        else if (t) m_pcnt = pre ? 0 : m_pcnt + 1;
        if (w && a == 2'd1) m_val = dd;
        else if (pre) m_val = hit ? (m_ctrl[1] ? m_load : '0) : m_val - 1;
        m_pend = hit || (m_pend && !(w && a == 2'd3));
        if (w && a == 2'd0) m_load = dd;
        if (w && a == 2'd2) m_ctrl = dd[4:0];
    endtask

    task automatic check(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [1:0] a, input logic [DW-1:0] dd, input logic t, input string tag);
        bus_wr = w; bus_addr = a; bus_wdata = dd; tick_en = t;
        @(posedge clk);
        model_step(w, a, dd, t);
        #1;
        check(tag, "rdata", bus_rdata, exp_rd(a));
        check(tag, "irq", {{(DW-1){1'b0}}, irq}, {{(DW-1){1'b0}}, m_pend & m_ctrl[2]});
    endtask

    task automatic run_ticks(input int n, input logic [1:0] a, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, a, '0, 1'b1, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        m_load = '0; m_val = '0; m_ctrl = '0; m_pend = 1'b0; m_pcnt = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int a = 0; a < 4; a++) step(1'b0, 2'(a), '0, 1'b0, "R1");

        step(1'b1, 2'd0, 32'd5, 1'b0, "R2");
        step(1'b0, 2'd1, '0, 1'b0, "R11");
        step(1'b1, 2'd1, 32'd3, 1'b0, "R10");
        step(1'b1, 2'd2, 32'hFFFF_FFE7, 1'b0, "R2");
        step(1'b1, 2'd2, 32'd7, 1'b0, "R2");
        run_ticks(3, 2'd1, "R3");
        run_ticks(1, 2'd1, "R5");
        step(1'b0, 2'd3, '0, 1'b0, "R6");
        step(1'b1, 2'd3, 32'hDEAD_BEEF, 1'b0, "R7");
        step(1'b0, 2'd3, '0, 1'b0, "R7");
        for (int i = 0; i < 14; i++) step(1'b1, 2'd3, '0, 1'b1, "R7");
        step(1'b1, 2'd0, 32'd9, 1'b1, "R11");
        step(1'b0, 2'd1, '0, 1'b0, "R11");
        step(1'b1, 2'd2, 32'd3, 1'b0, "R6");
        run_ticks(12, 2'd3, "R6");
        step(1'b1, 2'd2, 32'd0, 1'b1, "R9");
        run_ticks(20, 2'd1, "R9");
        step(1'b1, 2'd1, 32'd2, 1'b0, "R8");
        step(1'b1, 2'd2, 32'd5, 1'b0, "R8");
        run_ticks(6, 2'd1, "R8");
        step(1'b1, 2'd1, 32'd3, 1'b0, "R4");
        step(1'b1, 2'd2, 32'd11, 1'b0, "R4");
        run_ticks(80, 2'd1, "R4");
        step(1'b1, 2'd1, 32'd1, 1'b0, "R4");
        step(1'b1, 2'd2, 32'd19, 1'b0, "R4");
        run_ticks(600, 2'd1, "R4");
        step(1'b1, 2'd2, 32'd27, 1'b0, "R4");
        run_ticks(10, 2'd1, "R4");
        step(1'b1, 2'd2, 32'd7, 1'b0, "R10");
        step(1'b1, 2'd1, 32'd9, 1'b1, "R10");
        step(1'b1, 2'd1, 32'd0, 1'b1, "R10");
        step(1'b0, 2'd1, '0, 1'b1, "R5");

        for (int i = 0; i < 4000; i++) begin
            logic          w, t;
            logic [1:0]    a;
            logic [DW-1:0] dd;
            w  = ($urandom % 5) == 0;
            t  = ($urandom % 10) < 7;
            a  = 2'($urandom % 4);
            dd = (a == 2'd2) ? $urandom : 32'($urandom % 8);
            step(w, a, dd, t, "R2");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule